// File: doc/BRIEF.md
# Audio Serial Clock Generator

This block derives the three clocks of an audio serial port from a single kernel clock. A divider with an integer field and an odd-adjust bit sets a ratio of `2*DIV+ODD` kernel cycles. With the master clock output on, the divided clock appears on `mclk` at 256 times the frame rate for the two-channel standards and 128 times for the PCM standard. The bit clock is then derived from it. With the master clock output off, the divided clock is the bit clock itself.

A frame counter produces the word-select clock in one of four shapes. These are the Philips standard, left-justified, right-justified and a one-bit PCM frame pulse. Bit-clock polarity and word-select level can each be inverted. All configuration is sampled only while `enable` is low. A setting that cannot be realised raises `divInvalid` and keeps every clock at rest.

The serializer runs off `bclk` and `ws`. Software programs the settings while the block is stopped and then raises `enable`.

Top module: `aclkgen`

## Requirements
- R1: The divided clock has a period of `2*divField+divOdd` kernel cycles; with `mclkOutEn`=1 this is the period of `mclk`.
- R2: The divided clock is high for `divField+divOdd` cycles and low for `divField` cycles, so an odd ratio is within one kernel cycle of 50% duty.
- R3: `divField`=0 with `divOdd`=0 selects a ratio of 1: bits advance once per kernel cycle, and with `mclkOutEn`=1 the `mclk` pin stays high.
- R4: `divField`=1 with `divOdd`=1, or `divField` above 127, sets `divInvalid`=1; enabling with such a setting produces no clock edges.
- R5: With `mclkOutEn`=0, `mclk` stays low and `bclk` has the divider period, starting low for `divField+divOdd` cycles and then high for `divField` cycles.
- R6: With `mclkOutEn`=1, one `bclk` period spans 8 `mclk` periods when `chanLen32`=0 and 4 when `chanLen32`=1, at 50% duty, starting low.
- R7: A frame holds 32 bits (`chanLen32`=0) or 64 bits (`chanLen32`=1) for `stdSel` 0, 1 and 2, and 16 or 32 bits for `stdSel`=3.
- R8: Word-select shapes by `stdSel`: 0 (Philips) is low for the first half of the frame and moves one bit early, so it rises at bit F/2-1; 1 and 2 (left/right-justified) are high for the first half; 3 (PCM) is high only during bit 0.
- R9: `bclkInvert`=1 inverts `bclk` and `wsInvert`=1 inverts `ws` while running.
- R10: While not running, `mclk` is low. If `holdIdle`=1, `bclk` equals `bclkInvert` and `ws` equals `wsInvert`. If `holdIdle`=0, both are low.
- R11: Configuration inputs are sampled only while `enable` is low. Changes made while running, including to `divInvalid`, take effect after the next disable.
- R12: After reset, `mclk`, `bclk`, `ws` and `divInvalid` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Kernel clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Run request; configuration is sampled while low |
| divField | input | 8 | Integer divider field |
| divOdd | input | 1 | Odd-adjust bit of the divider |
| mclkOutEn | input | 1 | Drive the master clock and derive the bit clock from it |
| stdSel | input | 2 | Standard: 0 Philips, 1 left-justified, 2 right-justified, 3 PCM |
| chanLen32 | input | 1 | Channel length 32 bits when 1, 16 bits when 0 |
| bclkInvert | input | 1 | Invert the bit clock |
| wsInvert | input | 1 | Invert word select |
| holdIdle | input | 1 | Hold bit clock and word select at inactive levels while stopped |
| mclk | output | 1 | Master clock |
| bclk | output | 1 | Bit clock |
| ws | output | 1 | Word-select (frame) clock |
| divInvalid | output | 1 | Sampled divider setting is illegal |

## Verification
The assertions assume that configuration changes arrive while the block is stopped, or are otherwise ignored. They also assume that the divider counter only restarts from zero when a run begins. The bench therefore changes settings only with `enable` low, except in the freeze test. It always waits at least two kernel cycles before raising `enable`. Random configurations draw the divider field from a small legal range and clear the odd bit whenever it would form the illegal pair. The bench skips waveform measurement where a ratio of 1 makes a pin constant.

// File: rtl/aclkgen_pkg.sv
package aclkgen_pkg;

  typedef enum logic [1:0] {
    STD_PHILIPS = 2'd0,
    STD_LEFT    = 2'd1,
    STD_RIGHT   = 2'd2,
    STD_PCM     = 2'd3
  } stdSel_e;

  typedef struct packed {
    logic    run;       // clocks are being produced
    logic    divLevel;  // divided clock level in this kernel cycle
    logic    divWrap;   // last kernel cycle of a divided period
    logic    mclkOn;    // master clock output selected
    stdSel_e std;
    logic    chan32;
    logic    bclkInv;
    logic    wsInv;
    logic    holdIdle;
  } strobe_t;

endpackage

// File: rtl/aclkgen_ctrl.sv
module aclkgen_ctrl
  import aclkgen_pkg::*;
#(
  parameter int DIV_W   = 8,
  parameter int DIV_MAX = 127
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic [DIV_W-1:0] divIn,
  input  logic             oddIn,
  input  logic             mclkEnIn,
  input  logic [1:0]       stdIn,
  input  logic             chan32In,
  input  logic             bclkInvIn,
  input  logic             wsInvIn,
  input  logic             holdIdleIn,
  output strobe_t          strb,
  output logic             divInvalid
);

  localparam int CNT_W = DIV_W + 1;
  localparam logic [DIV_W-1:0] DIV_LIM = DIV_W'(DIV_MAX);

  logic [DIV_W-1:0] divQ;
  logic             oddQ, mclkEnQ, chan32Q, bclkInvQ, wsInvQ, holdIdleQ;
  stdSel_e          stdQ;

  // Configuration is captured only while the block is stopped.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      divQ      <= '0;
      oddQ      <= 1'b0;
      mclkEnQ   <= 1'b0;
      stdQ      <= STD_PHILIPS;
      chan32Q   <= 1'b0;
      bclkInvQ  <= 1'b0;
      wsInvQ    <= 1'b0;
      holdIdleQ <= 1'b0;
    end else if (!enable) begin
      divQ      <= divIn;
      oddQ      <= oddIn;
      mclkEnQ   <= mclkEnIn;
      stdQ      <= stdSel_e'(stdIn);
      chan32Q   <= chan32In;
      bclkInvQ  <= bclkInvIn;
      wsInvQ    <= wsInvIn;
      holdIdleQ <= holdIdleIn;
    end
  end

  logic cfgInvalid;
  assign cfgInvalid = ((divQ == DIV_W'(1)) && oddQ) || (divQ > DIV_LIM);
  assign divInvalid = cfgInvalid;

  logic [CNT_W-1:0] rawRatio, ratio, hiLen, cnt;
  assign rawRatio = {divQ, 1'b0} + CNT_W'(oddQ);
  assign ratio    = (rawRatio == '0) ? CNT_W'(1) : rawRatio;
  assign hiLen    = (rawRatio == '0) ? CNT_W'(1) : (CNT_W'(divQ) + CNT_W'(oddQ));

  logic run, lastCyc;
  assign run     = enable && !cfgInvalid;
  assign lastCyc = (cnt == ratio - CNT_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt <= '0;
    else if (!run)    cnt <= '0;
    else if (lastCyc) cnt <= '0;
    else              cnt <= cnt + CNT_W'(1);
  end

  always_comb begin
    strb.run      = run;
    strb.divLevel = (cnt < hiLen);
    strb.divWrap  = lastCyc;
    strb.mclkOn   = mclkEnQ;
    strb.std      = stdQ;
    strb.chan32   = chan32Q;
    strb.bclkInv  = bclkInvQ;
    strb.wsInv    = wsInvQ;
    strb.holdIdle = holdIdleQ;
  end

  logic pastValid;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pastValid <= 1'b0;
    else        pastValid <= 1'b1;
  end

  logic [DIV_W+8:0] cfgVec;
  assign cfgVec = {divQ, oddQ, mclkEnQ, stdQ, chan32Q, bclkInvQ, wsInvQ, holdIdleQ};

  // R1: the kernel-cycle counter never leaves the divider period
  a_r1_cnt_range: assert property (@(posedge clk) disable iff (!rst_n)
    cnt < ratio);

  // R4: an illegal setting keeps the divider counter parked
  a_r4_invalid_parked: assert property (@(posedge clk) disable iff (!rst_n)
    cfgInvalid |=> (cnt == '0));

  // R11: sampled configuration does not move while running
  a_r11_cfg_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (pastValid && $past(enable)) |-> $stable(cfgVec));

endmodule

// File: rtl/aclkgen_dp.sv
module aclkgen_dp
  import aclkgen_pkg::*;
#(
  parameter int BASE_FRAME   = 32,
  parameter int MCLK_PER_BIT = 8
) (
  input  logic    clk,
  input  logic    rst_n,
  input  strobe_t strb,
  output logic    mclk,
  output logic    bclk,
  output logic    ws
);

  localparam int IDX_W = $clog2(2 * BASE_FRAME) + 1;
  localparam int SUB_W = $clog2(MCLK_PER_BIT) + 1;

  logic [IDX_W-1:0] frameLen, halfLen, bitIdx, nextIdx;
  logic [SUB_W-1:0] subLen, subCnt;
  logic             subLast, bitEnd;

  always_comb begin
    frameLen = (strb.std == STD_PCM) ? IDX_W'(BASE_FRAME / 2) : IDX_W'(BASE_FRAME);
    if (strb.chan32) frameLen = frameLen << 1;
    halfLen = frameLen >> 1;
    subLen  = strb.chan32 ? SUB_W'(MCLK_PER_BIT / 2) : SUB_W'(MCLK_PER_BIT);
  end

  assign subLast = (subCnt == subLen - SUB_W'(1));
  assign bitEnd  = strb.run && strb.divWrap && (!strb.mclkOn || subLast);
  assign nextIdx = (bitIdx == frameLen - IDX_W'(1)) ? '0 : bitIdx + IDX_W'(1);

  // master clock periods within one bit
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                subCnt <= '0;
    else if (!strb.run)                        subCnt <= '0;
    else if (strb.mclkOn && strb.divWrap)      subCnt <= subLast ? '0 : subCnt + SUB_W'(1);
  end

  // bit position within the frame
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         bitIdx <= '0;
    else if (!strb.run) bitIdx <= '0;
    else if (bitEnd)    bitIdx <= nextIdx;
  end

  logic bclkLvl, wsLvl;
  always_comb begin
    bclkLvl = strb.mclkOn ? (subCnt >= (subLen >> 1)) : !strb.divLevel;
    unique case (strb.std)
      STD_PHILIPS:          wsLvl = (nextIdx >= halfLen);
      STD_LEFT, STD_RIGHT:  wsLvl = (bitIdx < halfLen);
      default:              wsLvl = (bitIdx == '0);
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mclk <= 1'b0;
      bclk <= 1'b0;
      ws   <= 1'b0;
    end else begin
      mclk <= strb.run && strb.mclkOn && strb.divLevel;
      bclk <= strb.run ? (bclkLvl ^ strb.bclkInv) : (strb.holdIdle & strb.bclkInv);
      ws   <= strb.run ? (wsLvl ^ strb.wsInv) : (strb.holdIdle & strb.wsInv);
    end
  end

  // R7: bit position stays inside the frame
  a_r7_bit_range: assert property (@(posedge clk) disable iff (!rst_n)
    bitIdx < frameLen);

  // R6: master-clock count stays inside one bit
  a_r6_sub_range: assert property (@(posedge clk) disable iff (!rst_n)
    subCnt < subLen);

  // R10: no master clock edge while stopped
  a_r10_idle_no_mclk: assert property (@(posedge clk) disable iff (!rst_n)
    !strb.run |=> !mclk);

endmodule

// File: rtl/aclkgen.sv
module aclkgen #(
  parameter int DIV_W        = 8,
  parameter int DIV_MAX      = 127,
  parameter int BASE_FRAME   = 32,
  parameter int MCLK_PER_BIT = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic [DIV_W-1:0] divField,
  input  logic             divOdd,
  input  logic             mclkOutEn,
  input  logic [1:0]       stdSel,
  input  logic             chanLen32,
  input  logic             bclkInvert,
  input  logic             wsInvert,
  input  logic             holdIdle,
  output logic             mclk,
  output logic             bclk,
  output logic             ws,
  output logic             divInvalid
);

  aclkgen_pkg::strobe_t strb;

  aclkgen_ctrl #(.DIV_W(DIV_W), .DIV_MAX(DIV_MAX)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .enable     (enable),
    .divIn      (divField),
    .oddIn      (divOdd),
    .mclkEnIn   (mclkOutEn),
    .stdIn      (stdSel),
    .chan32In   (chanLen32),
    .bclkInvIn  (bclkInvert),
    .wsInvIn    (wsInvert),
    .holdIdleIn (holdIdle),
    .strb       (strb),
    .divInvalid (divInvalid)
  );

  aclkgen_dp #(.BASE_FRAME(BASE_FRAME), .MCLK_PER_BIT(MCLK_PER_BIT)) u_dp (
    .clk   (clk),
    .rst_n (rst_n),
    .strb  (strb),
    .mclk  (mclk),
    .bclk  (bclk),
    .ws    (ws)
  );

endmodule

// File: tb/aclkgen_tb.sv
`timescale 1ns/1ps
module aclkgen_tb;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic enable = 1'b0;
  logic [7:0] divField = '0;
  logic divOdd = 1'b0, mclkOutEn = 1'b0, chanLen32 = 1'b0;
  logic [1:0] stdSel = '0;
  logic bclkInvert = 1'b0, wsInvert = 1'b0, holdIdle = 1'b0;
  logic mclk, bclk, ws, divInvalid;

  int checks = 0;
  int errors = 0;
  localparam int LIM = 30000;

  always #10 clk = ~clk;

  aclkgen u_dut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .divField(divField), .divOdd(divOdd),
    .mclkOutEn(mclkOutEn), .stdSel(stdSel), .chanLen32(chanLen32), .bclkInvert(bclkInvert),
    .wsInvert(wsInvert), .holdIdle(holdIdle), .mclk(mclk), .bclk(bclk), .ws(ws),
    .divInvalid(divInvalid)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int ratioOf(input int d, input int o);
    return (2 * d + o == 0) ? 1 : 2 * d + o;
  endfunction
  function automatic int hiOf(input int d, input int o);
    return (2 * d + o == 0) ? 1 : d + o;
  endfunction
  function automatic int bitPer(input int d, input int o, input int men, input int c32);
    return men ? ratioOf(d, o) * (c32 ? 4 : 8) : ratioOf(d, o);
  endfunction
  function automatic int frameOf(input int std, input int c32);
    return (std == 3 ? 16 : 32) * (c32 ? 2 : 1);
  endfunction

  function automatic logic sig(input int sel);
    return (sel == 0) ? mclk : (sel == 1) ? bclk : ws;
  endfunction

  task automatic setCfg(input int d, input int o, input int men, input int std,
                        input int c32, input int binv, input int winv, input int hold);
    divField = 8'(d); divOdd = 1'(o); mclkOutEn = 1'(men); stdSel = 2'(std);
    chanLen32 = 1'(c32); bclkInvert = 1'(binv); wsInvert = 1'(winv); holdIdle = 1'(hold);
  endtask

  // stop, load configuration, wait, start; returns at the negedge before the first run edge
  task automatic startWith(input int d, input int o, input int men, input int std,
                           input int c32, input int binv, input int winv);
    @(negedge clk);
    enable = 1'b0;
    setCfg(d, o, men, std, c32, binv, winv, 1);
    repeat (3) @(negedge clk);
    enable = 1'b1;
  endtask

  task automatic measure(input int sel, output int hi, output int lo);
    int g = 0;
    @(negedge clk);
    while (sig(sel) != 1'b0 && g < LIM) begin @(negedge clk); g++; end
    while (sig(sel) != 1'b1 && g < LIM) begin @(negedge clk); g++; end
    hi = 0;
    while (sig(sel) == 1'b1 && g < LIM) begin hi++; @(negedge clk); g++; end
    lo = 0;
    while (sig(sel) == 1'b0 && g < LIM) begin lo++; @(negedge clk); g++; end
  endtask

  task automatic firstChange(input int sel, output int v0, output int n);
    @(negedge clk);
    v0 = int'(sig(sel));
    n = 0;
    while (int'(sig(sel)) == v0 && n < LIM) begin @(negedge clk); n++; end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual 190000 cycles expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int hi, lo, v0, n, cnt;
    void'($urandom(32'd4242));
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R12 reset state
    check("R12 mclk", int'(mclk), 0);
    check("R12 bclk", int'(bclk), 0);
    check("R12 ws", int'(ws), 0);
    check("R12 divInvalid", int'(divInvalid), 0);

    // R10 idle levels
    setCfg(2, 0, 1, 0, 0, 1, 1, 1);
    repeat (3) @(negedge clk);
    check("R10 hold bclk", int'(bclk), 1);
    check("R10 hold ws", int'(ws), 1);
    check("R10 idle mclk", int'(mclk), 0);
    holdIdle = 1'b0;
    repeat (3) @(negedge clk);
    check("R10 nohold bclk", int'(bclk), 0);
    check("R10 nohold ws", int'(ws), 0);

    // R4 illegal settings
    setCfg(1, 1, 1, 0, 0, 0, 0, 1);
    repeat (3) @(negedge clk);
    check("R4 div1 odd1 flag", int'(divInvalid), 1);
    enable = 1'b1;
    cnt = 0;
    for (int i = 0; i < 40; i++) begin @(negedge clk); cnt += int'(mclk) + int'(bclk) + int'(ws); end
    check("R4 no edges when invalid", cnt, 0);
    enable = 1'b0;
    divField = 8'd128; divOdd = 1'b0;
    repeat (3) @(negedge clk);
    check("R4 div128 flag", int'(divInvalid), 1);
    divField = 8'd127; divOdd = 1'b1;
    repeat (3) @(negedge clk);
    check("R4 div127 odd legal", int'(divInvalid), 0);

    // R1/R2 ratio and duty
    startWith(127, 1, 1, 0, 0, 0, 0);
    measure(0, hi, lo);
    check("R2 ratio255 high", hi, 128);
    check("R1 ratio255 low", lo, 127);
    startWith(3, 0, 1, 0, 0, 0, 0);
    measure(0, hi, lo);
    check("R1 ratio6 high", hi, 3);
    check("R1 ratio6 low", lo, 3);
    startWith(2, 1, 1, 0, 0, 0, 0);
    measure(0, hi, lo);
    check("R2 ratio5 high", hi, 3);
    check("R2 ratio5 low", lo, 2);

    // R3 bypass
    startWith(0, 0, 0, 0, 0, 0, 0);
    measure(2, hi, lo);
    check("R3 bypass ws high", hi, 16);
    check("R3 bypass ws low", lo, 16);
    cnt = 0;
    for (int i = 0; i < 40; i++) begin @(negedge clk); cnt += int'(mclk); end
    check("R5 mclk quiet when off", cnt, 0);
    startWith(0, 0, 1, 0, 0, 0, 0);
    repeat (3) @(negedge clk);
    cnt = 0;
    for (int i = 0; i < 20; i++) begin @(negedge clk); cnt += int'(mclk); end
    check("R3 bypass mclk held high", cnt, 20);
    measure(1, hi, lo);
    check("R6 bypass bclk high", hi, 4);
    check("R6 bypass bclk low", lo, 4);

    // R6 bit clock from master clock
    startWith(2, 0, 1, 0, 0, 0, 0);
    measure(1, hi, lo);
    check("R6 chan16 bclk high", hi, 16);
    check("R6 chan16 bclk low", lo, 16);
    startWith(2, 0, 1, 0, 1, 0, 0);
    measure(1, hi, lo);
    check("R6 chan32 bclk high", hi, 8);
    check("R6 chan32 bclk low", lo, 8);
    startWith(0, 0, 1, 1, 1, 0, 0);
    measure(2, hi, lo);
    check("R7 frame64 ws high", hi, 128);
    check("R7 frame64 ws low", lo, 128);

    // R5 bit clock from divider
    startWith(2, 1, 0, 0, 0, 0, 0);
    firstChange(1, v0, n);
    check("R5 bclk starts low", v0, 0);
    check("R5 bclk first rise", n, 3);
    measure(1, hi, lo);
    check("R5 bclk high", hi, 2);
    check("R5 bclk low", lo, 3);
    startWith(2, 1, 0, 0, 0, 1, 0);
    measure(1, hi, lo);
    check("R9 inverted bclk high", hi, 3);
    check("R9 inverted bclk low", lo, 2);

    // R8 word-select shapes (bit period 2)
    startWith(1, 0, 0, 0, 0, 0, 0);
    firstChange(2, v0, n);
    check("R8 philips start", v0, 0);
    check("R8 philips early rise", n, 30);
    startWith(1, 0, 0, 1, 0, 0, 0);
    firstChange(2, v0, n);
    check("R8 left start", v0, 1);
    check("R8 left fall", n, 32);
    startWith(1, 0, 0, 2, 0, 0, 0);
    firstChange(2, v0, n);
    check("R8 right fall", n, 32);
    startWith(1, 0, 0, 3, 0, 0, 0);
    firstChange(2, v0, n);
    check("R8 pcm start", v0, 1);
    check("R8 pcm pulse", n, 2);
    startWith(1, 0, 0, 3, 1, 0, 0);
    measure(2, hi, lo);
    check("R7 pcm32 ws high", hi, 2);
    check("R7 pcm32 ws low", lo, 62);
    startWith(1, 0, 0, 1, 0, 0, 1);
    firstChange(2, v0, n);
    check("R9 ws inverted start", v0, 0);

    // R11 configuration frozen while running
    startWith(2, 0, 1, 0, 0, 0, 0);
    measure(0, hi, lo);
    check("R11 before change", hi + lo, 4);
    divField = 8'd5;
    measure(0, hi, lo);
    check("R11 change ignored", hi + lo, 4);
    divField = 8'd1; divOdd = 1'b1;
    repeat (3) @(negedge clk);
    check("R11 flag frozen", int'(divInvalid), 0);
    enable = 1'b0;
    repeat (3) @(negedge clk);
    check("R11 flag after stop", int'(divInvalid), 1);
    startWith(5, 0, 1, 0, 0, 0, 0);
    measure(0, hi, lo);
    check("R11 new ratio applied", hi + lo, 10);

    // random legal configurations
    for (int it = 0; it < 6; it++) begin
      int d, o, men, std, c32, winv, p, f, wh;
      d = $urandom_range(0, 5); o = $urandom_range(0, 1);
      if (d == 1) o = 0;
      men = $urandom_range(0, 1); std = $urandom_range(0, 3);
      c32 = $urandom_range(0, 1); winv = $urandom_range(0, 1);
      startWith(d, o, men, std, c32, 0, winv);
      p = bitPer(d, o, men, c32);
      f = frameOf(std, c32);
      wh = (std == 3) ? 1 : f / 2;
      if (men != 0 && ratioOf(d, o) > 1) begin
        measure(0, hi, lo);
        check("R1 random mclk high", hi, hiOf(d, o));
        check("R2 random mclk low", lo, ratioOf(d, o) - hiOf(d, o));
      end
      measure(2, hi, lo);
      check("R8 random ws high", hi, (winv != 0 ? f - wh : wh) * p);
      check("R7 random ws low", lo, (winv != 0 ? wh : f - wh) * p);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule